// File: doc/BRIEF.md
# Keypad Matrix Scanner with Debounce

This block reads a push-button matrix of up to 6 rows by 6 columns. Every row and column line is open-drain: the block either pulls a line low or lets go of it, and a released line reads high through its pull-up. A pressed key joins its row line to its column line. While no key is down, the block sits in a low-power wait with all rows pulled low. A falling column line wakes it. It then lets a programmable settle interval pass and reads the matrix again, so short spikes and contact bounce are rejected.

Two scan methods can be chosen. The fast method suits single presses. It pulls all rows low and reads the columns, then pulls all columns low and reads the rows, and it turns the two results into one scan code. The multi-key method pulls one row low at a time and collects a bitmap of every pressed key. Results leave on a valid/ready event stream. After a press, ambiguity or bitmap event, exactly one release event follows once all lines have read high for a full settle interval.

The stream follows these rules. An event stays on the outputs, unchanged, from the cycle `out_valid` rises until the cycle `out_ready` is sampled high. While the consumer holds `out_ready` low the scanner stalls and does no further scanning. The settle interval `cfg_settle` is a count of clock ticks. For 10 ms at a 50 MHz clock it is 500000.

Top module: `keyscan_matrix`

## Requirements
- R1: After reset no event is offered (`out_valid` low) and `sleep` is high.
- R2: In the idle wait `sleep` is high, every row drive is low (`row_drive_n` all 0) and every column is released (`col_drive_n` all 1). A column line read low wakes the block and makes `sleep` fall.
- R3: A wake is accepted only if some key still reads pressed after `cfg_settle` ticks. A press shorter than the interval gives no event and the block returns to sleep. A press longer than the interval, at any programmed value, gives an event.
- R4: In single-key mode (`mode_multi`=0), one pressed key at row r, column c gives an event of kind 0 (press) with `out_code` = r*COLS+c and `out_map` holding only bit r*COLS+c.
- R5: Row lines and column lines are never pulled low in the same cycle.
- R6: In single-key mode, more than one low row or more than one low column gives an event of kind 2 (ambiguous) with `out_code` 0 and `out_map` 0.
- R7: In multi-key mode (`mode_multi`=1), the event has kind 3 (bitmap), `out_code` 0, and `out_map` bit r*COLS+c set for exactly the keys held down, including keys that share a column.
- R8: During the multi-key row scan exactly one row is pulled low at a time, and every row gets its turn.
- R9: After a press, ambiguous or bitmap event, one release event of kind 1 is issued. It carries the previous event's `out_code` and an empty `out_map`, and it appears only after all columns have read high for `cfg_settle` consecutive ticks. Bounce shorter than that gives no release.
- R10: While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_kind`, `out_code` and `out_map` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_multi | input | 1 | 0 selects the two-phase single-key scan, 1 the per-row multi-key scan; sampled at wake |
| cfg_settle | input | CNT_W | Settle interval in clock ticks |
| row_in | input | ROWS | Row line levels (high when released and unpressed) |
| col_in | input | COLS | Column line levels |
| row_drive_n | output | ROWS | 0 pulls the row line low, 1 releases it |
| col_drive_n | output | COLS | 0 pulls the column line low, 1 releases it |
| sleep | output | 1 | High in the low-power wait |
| out_valid | output | 1 | Event offered |
| out_ready | input | 1 | Consumer accepts the event |
| out_kind | output | 2 | 0 press, 1 release, 2 ambiguous, 3 bitmap |
| out_code | output | CODE_W | Scan code r*COLS+c |
| out_map | output | ROWS*COLS | Pressed-key bitmap |

## Verification
The single-key scan is tried with one key in the middle of the matrix and with keys at both corner codes, which separates the row weight from the column weight in the code. Two keys on one row are used to show that the ambiguity check fires on the column phase. The multi-key scan is tried with keys scattered over different rows and columns, and with two keys sharing a column, which only a per-row scan can tell apart. A short spike, a press against a long settle interval, a release bounce and a stalled consumer separate spike rejection, the programmable interval, release debounce and back-pressure.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [1:0] {
    EV_PRESS   = 2'd0,
    EV_RELEASE = 2'd1,
    EV_AMBIG   = 2'd2,
    EV_MAP     = 2'd3
  } ev_kind_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/keyscan_sync.sv
module keyscan_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/keyscan_timer.sv
module keyscan_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt < limit)  cnt <= cnt + CW'(1);
  end

  assign done = (cnt >= limit);

  // once the interval has run out it stays out until cleared (R3)
  assert_timer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && $stable(limit)) |=> done);
endmodule

// File: rtl/keyscan_onehot.sv
module keyscan_onehot #(
  parameter int W  = 6,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          one,
  output logic          none
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign one  = ($countones(vec) == 1);
  assign none = (vec == '0);
endmodule

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
  import keyscan_pkg::*;
#(
  parameter int ROWS       = 6,
  parameter int COLS       = 6,
  parameter int CNT_W      = 20,
  parameter int PHASE_WAIT = 4,
  localparam int KEYS      = ROWS * COLS,
  localparam int CODE_W    = idx_w(KEYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_multi,
  input  logic [CNT_W-1:0]  cfg_settle,
  input  logic [ROWS-1:0]   row_in,
  input  logic [COLS-1:0]   col_in,
  output logic [ROWS-1:0]   row_drive_n,
  output logic [COLS-1:0]   col_drive_n,
  output logic              sleep,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [CODE_W-1:0] out_code,
  output logic [KEYS-1:0]   out_map
);
  localparam int RW  = idx_w(ROWS);
  localparam int CIW = idx_w(COLS);
  localparam logic [CODE_W:0] KEYS_V = (CODE_W+1)'(KEYS);

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_RDCOL, S_RDROW, S_ROWSCAN, S_EMIT, S_HOLD, S_EMITREL
  } st_t;

  st_t               state, state_nx;
  logic              multi_q;
  logic [RW-1:0]     row_idx;
  logic [CIW-1:0]    col_idx_q;
  logic              col_one_q;
  ev_kind_t          kind_q;
  logic [CODE_W-1:0] code_q;
  logic [KEYS-1:0]   map_q;

  logic [ROWS-1:0]   row_s, row_low;
  logic [COLS-1:0]   col_s, col_low;
  logic [CIW-1:0]    c_idx;
  logic [RW-1:0]     r_idx;
  logic              c_one, c_none, r_one, r_none;
  logic              t_clr, t_done, row_step;
  logic [CNT_W-1:0]  t_limit;
  logic [KEYS-1:0]   row_bits;
  logic [CODE_W-1:0] key_code;

  keyscan_sync #(.W(ROWS)) u_row_sync (.clk(clk), .rst_n(rst_n), .d(row_in), .q(row_s));
  keyscan_sync #(.W(COLS)) u_col_sync (.clk(clk), .rst_n(rst_n), .d(col_in), .q(col_s));

  assign row_low = ~row_s;
  assign col_low = ~col_s;

  keyscan_onehot #(.W(COLS), .IW(CIW)) u_col_enc (
    .vec(col_low), .idx(c_idx), .one(c_one), .none(c_none));
  keyscan_onehot #(.W(ROWS), .IW(RW)) u_row_enc (
    .vec(row_low), .idx(r_idx), .one(r_one), .none(r_none));

  keyscan_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .limit(t_limit), .done(t_done));

  assign row_bits = KEYS'(col_low) << (int'(row_idx) * COLS);
  assign key_code = CODE_W'(r_idx) * CODE_W'(COLS) + CODE_W'(col_idx_q);

  always_comb begin
    state_nx = state;
    row_step = 1'b0;
    case (state)
      S_IDLE:    if (col_s != '1) state_nx = S_SETTLE;
      S_SETTLE:  if (t_done) state_nx = multi_q ? S_ROWSCAN : S_RDCOL;
      S_RDCOL:   if (t_done) state_nx = c_none ? S_IDLE : S_RDROW;
      S_RDROW:   if (t_done) state_nx = r_none ? S_IDLE : S_EMIT;
      S_ROWSCAN: if (t_done) begin
        if (row_idx == RW'(ROWS-1))
          state_nx = ((map_q | row_bits) != '0) ? S_EMIT : S_IDLE;
        else
          row_step = 1'b1;
      end
      S_EMIT:    if (out_ready) state_nx = S_HOLD;
      S_HOLD:    if (t_done && col_s == '1) state_nx = S_EMITREL;
      S_EMITREL: if (out_ready) state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  assign t_clr   = (state_nx != state) || row_step || (state == S_HOLD && col_s != '1);
  assign t_limit = (state == S_SETTLE || state == S_HOLD) ? cfg_settle : CNT_W'(PHASE_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      multi_q   <= 1'b0;
      row_idx   <= '0;
      col_idx_q <= '0;
      col_one_q <= 1'b0;
      kind_q    <= EV_PRESS;
      code_q    <= '0;
      map_q     <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE && state_nx == S_SETTLE) multi_q <= mode_multi;
      if (state == S_SETTLE && state_nx == S_ROWSCAN) begin
        row_idx <= '0;
        map_q   <= '0;
      end
      if (state == S_RDCOL && t_done) begin
        col_idx_q <= c_idx;
        col_one_q <= c_one;
      end
      if (state == S_RDROW && t_done && !r_none) begin
        if (col_one_q && r_one) begin
          kind_q <= EV_PRESS;
          code_q <= key_code;
          map_q  <= KEYS'(1) << key_code;
        end else begin
          kind_q <= EV_AMBIG;
          code_q <= '0;
          map_q  <= '0;
        end
      end
      if (state == S_ROWSCAN && t_done) begin
        map_q <= map_q | row_bits;
        if (row_step) row_idx <= row_idx + RW'(1);
        if (state_nx == S_EMIT) begin
          kind_q <= EV_MAP;
          code_q <= '0;
        end
      end
    end
  end

  always_comb begin
    row_drive_n = '0;
    col_drive_n = '1;
    case (state)
      S_RDROW: begin
        row_drive_n = '1;
        col_drive_n = '0;
      end
      S_ROWSCAN: row_drive_n = ~(ROWS'(1) << row_idx);
      default: ;
    endcase
  end

  assign sleep     = (state == S_IDLE);
  assign out_valid = (state == S_EMIT) || (state == S_EMITREL);
  assign out_kind  = (state == S_EMITREL) ? EV_RELEASE : kind_q;
  assign out_code  = code_q;
  assign out_map   = (state == S_EMITREL) ? '0 : map_q;

  assert_sleep_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (row_drive_n == '0 && col_drive_n == '1));

  assert_no_cross_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((row_drive_n != '1) && (col_drive_n != '1)));

  assert_one_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_drive_n == '1 && row_drive_n != '0) |-> $countones(~row_drive_n) == 1);

  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == EV_PRESS) |-> ({1'b0, out_code} < KEYS_V));

  assert_ambig_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == EV_AMBIG) |-> (out_code == '0 && out_map == '0));

  assert_stall_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_kind) && $stable(out_code) && $stable(out_map)));
endmodule

// File: tb/keyscan_matrix_tb.sv
module keyscan_matrix_tb;
  import keyscan_pkg::*;

  localparam int ROWS = 6;
  localparam int COLS = 6;
  localparam int KEYS = 36;
  localparam int CODE_W = 6;
  localparam int CNT_W = 20;

  typedef struct packed {
    logic [1:0]        kind;
    logic [CODE_W-1:0] code;
    logic [KEYS-1:0]   map;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_multi = 1'b0;
  logic [CNT_W-1:0] cfg_settle = 20'd40;
  logic [ROWS-1:0] row_in, row_drive_n;
  logic [COLS-1:0] col_in, col_drive_n;
  logic sleep, out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [CODE_W-1:0] out_code;
  logic [KEYS-1:0] out_map;
  logic [KEYS-1:0] keys = '0;
  logic [ROWS-1:0] seen_alone = '0;

  ev_t   exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  keyscan_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .cfg_settle(cfg_settle),
    .row_in(row_in), .col_in(col_in), .row_drive_n(row_drive_n), .col_drive_n(col_drive_n),
    .sleep(sleep), .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_code(out_code), .out_map(out_map));

  // matrix model: a pressed key joins its row and column; pulled-up lines
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_in[r] = row_drive_n[r];
      for (int c = 0; c < COLS; c++)
        if (keys[r*COLS+c] && !col_drive_n[c]) row_in[r] = 1'b0;
    end
    for (int c = 0; c < COLS; c++) begin
      col_in[c] = col_drive_n[c];
      for (int r = 0; r < ROWS; r++)
        if (keys[r*COLS+c] && !row_drive_n[r]) col_in[c] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input int code, input logic [KEYS-1:0] m, input string req);
    ev_t e;
    e.kind = k;
    e.code = CODE_W'(code);
    e.map  = m;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    ev_t got, want;
    string tg;
    if (rst_n && out_valid && out_ready) begin
      got = {out_kind, out_code, out_map};
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R9 unexpected event", 64'(got), 64'h0);
      end else begin
        want = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(got === want, tg, 64'(got), 64'(want));
      end
    end
    for (int r = 0; r < ROWS; r++)
      if (row_drive_n == ~(ROWS'(1) << r)) seen_alone[r] = 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin
      @(posedge clk);
      n++;
    end
    #1;
    check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
  endtask

  task automatic single_key(input int r, input int c);
    int code = r*COLS + c;
    expect_ev(EV_PRESS, code, KEYS'(1) << code, "R4 press code");
    keys = KEYS'(1) << code;
    drain("R4 press arrives");
    expect_ev(EV_RELEASE, code, '0, "R9 release code");
    keys = '0;
    drain("R9 release arrives");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ev_t snap;
    bit  stable_ok;
    int  n;
    tick(5);
    rst_n = 1'b1;
    @(negedge clk);
    check(sleep == 1'b1, "R1 sleep after reset", 64'(sleep), 64'h1);
    check(out_valid == 1'b0, "R1 no event after reset", 64'(out_valid), 64'h0);
    check(row_drive_n == '0, "R2 idle rows low", 64'(row_drive_n), 64'h0);
    check(col_drive_n == '1, "R2 idle columns released", 64'(col_drive_n), 64'h3f);

    // R2 wake then R4 single key in the middle
    expect_ev(EV_PRESS, 15, KEYS'(1) << 15, "R4 press r2c3");
    tick(1);
    keys = KEYS'(1) << 15;
    tick(6);
    @(negedge clk);
    check(sleep == 1'b0, "R2 wake on column", 64'(sleep), 64'h0);
    drain("R4 press r2c3 arrives");
    expect_ev(EV_RELEASE, 15, '0, "R9 release r2c3");
    keys = '0;
    drain("R9 release r2c3 arrives");
    tick(5);
    @(negedge clk);
    check(sleep == 1'b1, "R2 back to sleep", 64'(sleep), 64'h1);

    // R4 corner codes
    tick(1);
    single_key(0, 0);
    single_key(5, 5);

    // R3 short spike against a long interval: no event
    cfg_settle = 20'd200;
    keys = KEYS'(1) << 19;
    tick(20);
    keys = '0;
    tick(600);
    @(negedge clk);
    check(sleep == 1'b1, "R3 spike rejected, asleep", 64'(sleep), 64'h1);
    check(exp_q.size() == 0, "R3 spike gives no event", 64'(exp_q.size()), 64'h0);
    // R3 sustained press with the longer interval
    tick(1);
    single_key(3, 1);
    cfg_settle = 20'd40;

    // R6 two keys on one row
    expect_ev(EV_AMBIG, 0, '0, "R6 ambiguous");
    keys = (KEYS'(1) << 7) | (KEYS'(1) << 10);
    drain("R6 ambiguous arrives");
    expect_ev(EV_RELEASE, 0, '0, "R9 release after ambiguous");
    keys = '0;
    drain("R9 release after ambiguous arrives");

    // R7/R8 multi-key, scattered
    mode_multi = 1'b1;
    seen_alone = '0;
    expect_ev(EV_MAP, 0, (KEYS'(1) << 2) | (KEYS'(1) << 21) | (KEYS'(1) << 30), "R7 bitmap scattered");
    keys = (KEYS'(1) << 2) | (KEYS'(1) << 21) | (KEYS'(1) << 30);
    drain("R7 bitmap scattered arrives");
    check(seen_alone == '1, "R8 each row driven alone", 64'(seen_alone), 64'h3f);
    expect_ev(EV_RELEASE, 0, '0, "R9 release after bitmap");
    keys = '0;
    drain("R9 release after bitmap arrives");
    // R7 shared column
    expect_ev(EV_MAP, 0, (KEYS'(1) << 8) | (KEYS'(1) << 26), "R7 bitmap shared column");
    keys = (KEYS'(1) << 8) | (KEYS'(1) << 26);
    drain("R7 bitmap shared column arrives");
    expect_ev(EV_RELEASE, 0, '0, "R9 release shared column");
    keys = '0;
    drain("R9 release shared column arrives");
    mode_multi = 1'b0;

    // R10 back-pressure
    out_ready = 1'b0;
    expect_ev(EV_PRESS, 25, KEYS'(1) << 25, "R10 stalled press");
    keys = KEYS'(1) << 25;
    n = 0;
    @(negedge clk);
    while (!out_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    snap = {out_kind, out_code, out_map};
    stable_ok = out_valid;
    repeat (30) begin
      @(negedge clk);
      if (!out_valid || {out_kind, out_code, out_map} != snap) stable_ok = 1'b0;
    end
    check(stable_ok, "R10 held while stalled", 64'(stable_ok), 64'h1);
    tick(1);
    out_ready = 1'b1;
    drain("R10 stalled press arrives");

    // R9 release bounce shorter than the interval
    keys = '0;
    tick(10);
    keys = KEYS'(1) << 25;
    tick(100);
    @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R9 bounce gives no release", 64'(out_valid), 64'h0);
    tick(1);
    expect_ev(EV_RELEASE, 25, '0, "R9 release after bounce");
    keys = '0;
    drain("R9 release after bounce arrives");

    tick(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule